// File: doc/BRIEF.md
# Counting Semaphore Cell

A single storage cell that threads share to coordinate with one another. It sits on a simple register bus. Each request carries a strobe, a direction, a view select (sync or try) and the 6-bit ID of the requesting thread. A read is an acquire (P): it returns the current count and takes one unit from it. A write is a release (V): it adds one unit. No write data is carried.

When a sync acquire finds the count empty, the cell answers with a stall. It also records the requester in a 64-bit blocked mask. The next release sends a one-cycle wake vector with every recorded thread in it and empties the mask. A woken thread must then issue its acquire again. A static mode input switches the cell into a queue role. In that role the acquire/release behaviour is disabled and the counter is frozen.

Top module: `sem_cell`

## Requirements
- R1: After reset the count is 0, the blocked mask is empty, and `rsp_valid`, `rsp_stall` and `wake_vec` are all 0.
- R2: Every accepted request is answered exactly one cycle later with `rsp_valid`=1. A P-read (`req_write`=0) returns in `rsp_data` the count as it stood before the request.
- R3: A P-read decrements the count by one when the count is non-zero. It leaves a zero count unchanged.
- R4: A P-read at zero count with `req_view`=1 (sync) answers `rsp_stall`=1 and sets bit `req_tid` of the blocked mask. With `req_view`=0 (try) the same read answers data 0 and `rsp_stall`=0, and records nothing.
- R5: A V-write (`req_write`=1) increments the count by one. The sync and try views give the same result.
- R6: The count saturates at 0xFFFF. A V-write at 0xFFFF leaves it at 0xFFFF.
- R7: A V-write made while the blocked mask is non-empty drives `wake_vec` with that mask for exactly one cycle, starting one cycle after the write, and empties the mask. `wake_vec` is 0 in all other cycles.
- R8: While `queue_mode`=1, a read answers data 0 with no stall, a write has no effect, and neither changes the count or the mask.
- R9: A write is answered with `rsp_data`=0 and `rsp_stall`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| queue_mode | input | 1 | 1 disables the semaphore behaviour (the cell is used as a queue) |
| req_valid | input | 1 | Request strobe, one request per cycle |
| req_write | input | 1 | 1 = V (release), 0 = P (acquire) |
| req_view | input | 1 | 1 = sync view (blocks at zero), 0 = try view |
| req_tid | input | 6 | ID of the requesting thread |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_data | output | 16 | Count before the acquire; 0 for writes and in queue mode |
| rsp_stall | output | 1 | The requester was blocked and must retry once woken |
| wake_vec | output | 64 | One-cycle pulse holding the blocked threads being released |

## Verification
The assertions assume that `queue_mode` is static while requests flow. They also assume that a single bus master issues at most one request per cycle, so an acquire and a release never share a cycle. The stimulus changes `queue_mode` only on idle cycles. It drives exactly one request per call, always on the falling edge. Blocked-thread IDs include both ends of the range (0 and 63), which exercises the mask bounds. The saturation case is reached by a long run of back-to-back releases, not by any preload path.

// File: rtl/semcell_pkg.sv
package semcell_pkg;

    typedef enum logic {
        VIEW_TRY  = 1'b0,
        VIEW_SYNC = 1'b1
    } view_e;

endpackage

// File: rtl/sem_count_step.sv
module sem_count_step #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] count_q,
    input  logic             dec_req,
    input  logic             inc_req,
    output logic [CNT_W-1:0] count_d,
    output logic             nonzero,
    output logic             at_max
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_comb begin
        nonzero = (count_q != '0);
        at_max  = (count_q == CNT_MAX);
        count_d = count_q;
        if (inc_req && !at_max) begin
            count_d = count_q + 1'b1;
        end else if (dec_req && nonzero) begin
            count_d = count_q - 1'b1;
        end
    end
endmodule

// File: rtl/sem_wait_step.sv
module sem_wait_step #(
    parameter int TID_W = 6,
    parameter int THREADS = 1 << TID_W
) (
    input  logic [THREADS-1:0] blocked_q,
    input  logic               set_en,
    input  logic [TID_W-1:0]   set_tid,
    input  logic               release_en,
    output logic [THREADS-1:0] blocked_d,
    output logic [THREADS-1:0] wake_d
);
    for (genvar i = 0; i < THREADS; i++) begin : g_bit
        logic hit;
        assign hit          = set_en && (set_tid == TID_W'(i));
        assign blocked_d[i] = release_en ? 1'b0 : (blocked_q[i] | hit);
        assign wake_d[i]    = release_en & blocked_q[i];
    end
endmodule

// File: rtl/sem_cell.sv
module sem_cell
    import semcell_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int TID_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               queue_mode,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic               req_view,
    input  logic [TID_W-1:0]   req_tid,
    output logic               rsp_valid,
    output logic [CNT_W-1:0]   rsp_data,
    output logic               rsp_stall,
    output logic [(1<<TID_W)-1:0] wake_vec
);
    localparam int THREADS = 1 << TID_W;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0]   count;
        logic [THREADS-1:0] blocked;
        logic [THREADS-1:0] wake;
        logic               rsp_valid;
        logic [CNT_W-1:0]   rsp_data;
        logic               rsp_stall;
    } state_t;

    state_t st_d, st_q;

    logic               live;
    logic               p_op, v_op, block_now;
    logic               cnt_nonzero, cnt_at_max;
    logic [CNT_W-1:0]   cnt_next;
    logic [THREADS-1:0] blk_next, wake_next;

    assign live      = req_valid && !queue_mode;
    assign p_op      = live && !req_write;
    assign v_op      = live && req_write;
    assign block_now = p_op && (view_e'(req_view) == VIEW_SYNC) && !cnt_nonzero;

    sem_count_step #(.CNT_W(CNT_W)) u_count (
        .count_q (st_q.count),
        .dec_req (p_op),
        .inc_req (v_op),
        .count_d (cnt_next),
        .nonzero (cnt_nonzero),
        .at_max  (cnt_at_max)
    );

    sem_wait_step #(.TID_W(TID_W), .THREADS(THREADS)) u_wait (
        .blocked_q  (st_q.blocked),
        .set_en     (block_now),
        .set_tid    (req_tid),
        .release_en (v_op),
        .blocked_d  (blk_next),
        .wake_d     (wake_next)
    );

    always_comb begin
        st_d           = st_q;
        st_d.count     = cnt_next;
        st_d.blocked   = blk_next;
        st_d.wake      = wake_next;
        st_d.rsp_valid = req_valid;
        st_d.rsp_data  = p_op ? st_q.count : '0;
        st_d.rsp_stall = block_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.rsp_valid;
    assign rsp_data  = st_q.rsp_data;
    assign rsp_stall = st_q.rsp_stall;
    assign wake_vec  = st_q.wake;

    // R2: acquire returns the pre-request count one cycle later
    p_read_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !queue_mode) |=> (rsp_valid && rsp_data == $past(st_q.count)));

    // R3: non-zero count drops by one on acquire
    p_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !queue_mode && st_q.count != '0)
        |=> (st_q.count == $past(st_q.count) - 1'b1));

    // R4: sync acquire at zero stalls and records the thread
    p_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_view && !queue_mode && st_q.count == '0)
        |=> (rsp_stall && st_q.blocked[$past(req_tid)]));

    // R4: try acquire at zero never stalls
    p_try_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !req_view && !queue_mode && st_q.count == '0)
        |=> (!rsp_stall && rsp_data == '0 && st_q.blocked == $past(st_q.blocked)));

    // R6: saturation holds the maximum
    p_sat_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !queue_mode && st_q.count == CNT_MAX)
        |=> (st_q.count == CNT_MAX));

    // R7: release wakes the recorded threads and empties the mask
    p_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !queue_mode)
        |=> (wake_vec == $past(st_q.blocked) && st_q.blocked == '0));

    // R7: wake lasts one cycle
    p_wake_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_vec != '0) |=> (wake_vec == '0));

    // R8: queue mode freezes the counter and answers zero
    p_queue_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && queue_mode)
        |=> ($stable(st_q.count) && rsp_data == '0 && !rsp_stall));

    // R9: write responses carry no data and no stall
    p_write_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> (rsp_valid && rsp_data == '0 && !rsp_stall));

endmodule

// File: tb/sem_cell_test.sv
module sem_cell_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        queue_mode = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_view = 1'b0;
    logic [5:0]  req_tid = '0;
    logic        rsp_valid;
    logic [15:0] rsp_data;
    logic        rsp_stall;
    logic [63:0] wake_vec;

    int n_checks = 0;
    int n_fail = 0;

    typedef struct {
        logic [15:0] data;
        logic        stall;
        logic [63:0] wake;
        string       tag;
    } exp_t;

    exp_t sb[$];

    logic [15:0] m_cnt = '0;
    logic [63:0] m_blk = '0;
    logic        mon_on = 1'b0;

    sem_cell uut (
        .clk(clk), .rst_n(rst_n), .queue_mode(queue_mode),
        .req_valid(req_valid), .req_write(req_write), .req_view(req_view),
        .req_tid(req_tid), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rsp_stall(rsp_stall), .wake_vec(wake_vec)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // driver: one request per call, predicts and queues the response
    task automatic op(input logic wr, input logic sync, input logic [5:0] tid, input string tag);
        exp_t e;
        e.data = '0; e.stall = 1'b0; e.wake = '0; e.tag = tag;
        if (!queue_mode) begin
            if (!wr) begin
                e.data = m_cnt;
                if (m_cnt != 0) m_cnt = m_cnt - 1'b1;
                else if (sync) begin e.stall = 1'b1; m_blk[tid] = 1'b1; end
            end else begin
                if (m_cnt != 16'hFFFF) m_cnt = m_cnt + 1'b1;
                e.wake = m_blk;
                m_blk = '0;
            end
        end
        sb.push_back(e);
        req_valid = 1'b1; req_write = wr; req_view = sync; req_tid = tid;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // monitor: pops and compares on the falling edge
    always @(negedge clk) begin
        if (mon_on) begin
            if (rsp_valid) begin
                if (sb.size() == 0) begin
                    chk("R2 unexpected response", 64'd1, 64'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk({e.tag, " data"}, 64'(rsp_data), 64'(e.data));
                    chk({e.tag, " stall"}, 64'(rsp_stall), 64'(e.stall));
                    chk({e.tag, " wake R7"}, wake_vec, e.wake);
                end
            end else begin
                chk("R7 idle wake", wake_vec, 64'd0);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R1 rsp_stall", 64'(rsp_stall), 64'd0);
        chk("R1 wake_vec", wake_vec, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        mon_on = 1'b1;

        op(1'b0, 1'b0, 6'd1, "R1 R4 try at zero");
        op(1'b0, 1'b1, 6'd5, "R4 sync block tid5");
        op(1'b0, 1'b1, 6'd63, "R4 sync block tid63");
        op(1'b0, 1'b1, 6'd0, "R4 sync block tid0");
        op(1'b1, 1'b1, 6'd2, "R7 R9 release wakes");
        op(1'b1, 1'b0, 6'd2, "R5 R7 try release no wake");
        op(1'b0, 1'b1, 6'd3, "R2 R3 sync acquire");
        op(1'b0, 1'b0, 6'd3, "R2 R3 try acquire");
        op(1'b0, 1'b0, 6'd3, "R3 R4 try at zero again");
        op(1'b1, 1'b1, 6'd4, "R7 release empty mask");
        op(1'b1, 1'b0, 6'd4, "R5 try release");
        @(negedge clk);

        queue_mode = 1'b1;
        @(negedge clk);
        op(1'b0, 1'b1, 6'd7, "R8 queue read");
        op(1'b1, 1'b1, 6'd7, "R8 queue write");
        @(negedge clk);
        queue_mode = 1'b0;
        @(negedge clk);
        op(1'b0, 1'b0, 6'd7, "R8 count unchanged");
        op(1'b0, 1'b0, 6'd7, "R3 to zero");

        for (int i = 0; i < 65536; i++) op(1'b1, i[0], 6'd9, "R5 R6 fill");
        op(1'b1, 1'b1, 6'd9, "R6 saturate again");
        op(1'b0, 1'b0, 6'd9, "R6 read max");
        op(1'b0, 1'b1, 6'd9, "R3 read below max");
        repeat (3) @(negedge clk);
        mon_on = 1'b0;
        chk("R2 all responses seen", 64'(sb.size()), 64'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R2 watchdog expired: actual hang expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule